// File: doc/BRIEF.md
# i80 Parallel LCD Write Sequencer

This block carries out single write transfers on an 8080-style parallel bus that feeds an LCD panel. A client offers one word at a time on a valid/ready request port, together with a flag that says whether the word is a command or display data. When the block accepts a word, it stores the payload and the four phase lengths. It then moves the bus through four timed phases: register-select setup with chip select still high, chip-select-to-strobe setup, the write strobe itself, and a hold phase in which chip select stays low after the strobe ends. When chip select returns high it raises a one-cycle completion pulse.

Each phase lasts its programmed 4-bit length plus one clock of the internal video clock. When `cfg_use` is low, built-in lengths apply: 0 for both setup phases and for the hold, and 1 for the strobe. The request port applies back-pressure the usual way. `req_ready` is high only while the sequencer is idle. A client that raises `req_valid` must hold it, together with `req_cmd` and `req_data`, until it samples `req_ready` high at a rising edge, and that edge is the transfer. The lengths on the `cfg_*` pins are taken at the same edge. Changes on the request and configuration pins during a transfer do not affect it.

Top module: `i80w_seq`

## Requirements
- R1: `req_ready` is high and `busy` low exactly while the sequencer is idle. A word is accepted only at a rising edge where `req_valid` and `req_ready` are both high, and a request held during a transfer waits.
- R2: In the first cycle after acceptance, `lcd_rs` shows the request type: 0 for a command (`req_cmd`=1), 1 for data. `lcd_cs_n` and `lcd_wr_n` then stay high for cs_setup+1 cycles.
- R3: `lcd_cs_n` then goes low while `lcd_wr_n` stays high for wr_setup+1 cycles.
- R4: `lcd_wr_n` then goes low for wr_active+1 cycles, with `lcd_cs_n` low.
- R5: After `lcd_wr_n` rises, `lcd_cs_n` stays low for wr_hold+1 cycles and is then released high.
- R6: `lcd_data_oe` is high, and `lcd_data` carries the accepted word, from the first strobe cycle until chip select rises. `lcd_data_oe` is low at all other times.
- R7: With `cfg_use` low, the phase lengths used are cs_setup=0, wr_setup=0, wr_active=1 and wr_hold=0, whatever the `cfg_*` pins carry.
- R8: Phase lengths, type flag and data word are sampled at acceptance. Changing the request or configuration pins during a transfer does not change its timing or its bus values, and `lcd_data`/`lcd_rs` stay stable while chip select is low.
- R9: `done` is a one-cycle pulse, high exactly in the cycle in which `lcd_cs_n` returns high at the end of a transfer.
- R10: Between two transfers `lcd_cs_n` is high for at least one idle cycle. A request that is waiting is accepted at the end of the `done` cycle.
- R11: A synchronous active-high `rst` forces idle: `lcd_cs_n`=1, `lcd_wr_n`=1, `lcd_data_oe`=0, `done`=0, `req_ready`=1, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal video clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_use | input | 1 | 1: use `cfg_*` lengths; 0: built-in lengths |
| cfg_cs_setup | input | 4 | Setup from register select to chip select, minus one |
| cfg_wr_setup | input | 4 | Setup from chip select to strobe, minus one |
| cfg_wr_active | input | 4 | Strobe width, minus one |
| cfg_wr_hold | input | 4 | Hold from strobe release to chip-select release, minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cmd | input | 1 | 1: command word, 0: display data |
| req_data | input | 8 | Word to write |
| lcd_rs | output | 1 | Register select (0 command, 1 data) |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_data | output | 8 | Data bus value |
| lcd_data_oe | output | 1 | Data bus output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a request that arrives while a transfer is under way and is then taken in the very cycle `done` pulses. The stimulus gets there by queueing several transfers back to back: it raises `req_valid` again right after each acceptance, so the request is already waiting through the whole of the previous transfer. A second awkward case is a reset that lands while the strobe is low. The bench programs a long strobe, counts into it and then pulses reset. A third is the sampling rule. Right after acceptance the bench rewrites the request and configuration pins with unrelated values, and the monitor still expects the waveform of the values that were accepted.

// File: rtl/i80w_pkg.sv
package i80w_pkg;
  localparam int PH_N = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_CSSU = 3'd2,
    ST_STRB = 3'd3,
    ST_HOLD = 3'd4
  } seq_st_e;

  // index of each phase length in the length arrays
  localparam int PH_ADDR = 0;
  localparam int PH_CSSU = 1;
  localparam int PH_STRB = 2;
  localparam int PH_HOLD = 3;
endpackage

// File: rtl/i80w_req_latch.sv
module i80w_req_latch
  import i80w_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TW      = 4,
  parameter int DEF_CS  = 0,
  parameter int DEF_WS  = 0,
  parameter int DEF_WA  = 1,
  parameter int DEF_WH  = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  logic                     use_cfg,
  input  logic [PH_N-1:0][TW-1:0]  cfg_len,
  input  logic                     cmd,
  input  logic [DW-1:0]            data,
  output logic [PH_N-1:0][TW-1:0]  sel_len,
  output logic [PH_N-1:0][TW-1:0]  len_q,
  output logic                     rs_q,
  output logic [DW-1:0]            data_q
);
  for (genvar p = 0; p < PH_N; p++) begin : g_len
    localparam int DEF_I = (p == PH_ADDR) ? DEF_CS :
                           (p == PH_CSSU) ? DEF_WS :
                           (p == PH_STRB) ? DEF_WA : DEF_WH;
    localparam logic [TW-1:0] DEF_V = TW'(DEF_I);

    assign sel_len[p] = use_cfg ? cfg_len[p] : DEF_V;

    always_ff @(posedge clk) begin
      if (rst)          len_q[p] <= DEF_V;
      else if (capture) len_q[p] <= sel_len[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q   <= 1'b1;
      data_q <= '0;
    end else if (capture) begin
      rs_q   <= ~cmd;
      data_q <= data;
    end
  end
endmodule

// File: rtl/i80w_phase_cnt.sv
module i80w_phase_cnt #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/i80w_pin_drv.sv
module i80w_pin_drv
  import i80w_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  seq_st_e st_next,
  output logic    cs_n,
  output logic    wr_n,
  output logic    oe
);
  logic cs_d, wr_d, oe_d;

  always_comb begin
    cs_d = (st_next == ST_CSSU) || (st_next == ST_STRB) || (st_next == ST_HOLD);
    wr_d = (st_next == ST_STRB);
    oe_d = (st_next == ST_STRB) || (st_next == ST_HOLD);
  end

  // registered pins: no decode glitches reach the panel
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= 1'b1;
      wr_n <= 1'b1;
      oe   <= 1'b0;
    end else begin
      cs_n <= ~cs_d;
      wr_n <= ~wr_d;
      oe   <= oe_d;
    end
  end
endmodule

// File: rtl/i80w_seq.sv
module i80w_seq
  import i80w_pkg::*;
#(
  parameter int DW     = 8,
  parameter int TW     = 4,
  parameter int DEF_CS = 0,
  parameter int DEF_WS = 0,
  parameter int DEF_WA = 1,
  parameter int DEF_WH = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_use,
  input  logic [TW-1:0] cfg_cs_setup,
  input  logic [TW-1:0] cfg_wr_setup,
  input  logic [TW-1:0] cfg_wr_active,
  input  logic [TW-1:0] cfg_wr_hold,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_cmd,
  input  logic [DW-1:0] req_data,
  output logic          lcd_rs,
  output logic          lcd_cs_n,
  output logic          lcd_wr_n,
  output logic [DW-1:0] lcd_data,
  output logic          lcd_data_oe,
  output logic          busy,
  output logic          done
);
  seq_st_e st_q, st_d;
  logic    accept;
  logic    cnt_load, cnt_last, done_d;
  logic [TW-1:0] cnt_val;
  logic [PH_N-1:0][TW-1:0] cfg_len, sel_len, len_q;

  assign cfg_len[PH_ADDR] = cfg_cs_setup;
  assign cfg_len[PH_CSSU] = cfg_wr_setup;
  assign cfg_len[PH_STRB] = cfg_wr_active;
  assign cfg_len[PH_HOLD] = cfg_wr_hold;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign accept    = req_valid && req_ready;

  i80w_req_latch #(
    .DW(DW), .TW(TW),
    .DEF_CS(DEF_CS), .DEF_WS(DEF_WS), .DEF_WA(DEF_WA), .DEF_WH(DEF_WH)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (accept),
    .use_cfg (cfg_use),
    .cfg_len (cfg_len),
    .cmd     (req_cmd),
    .data    (req_data),
    .sel_len (sel_len),
    .len_q   (len_q),
    .rs_q    (lcd_rs),
    .data_q  (lcd_data)
  );

  i80w_phase_cnt #(.TW(TW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  // phase sequencing: each phase runs its length plus one cycle
  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d     = ST_ADDR;
        cnt_load = 1'b1;
        cnt_val  = sel_len[PH_ADDR];
      end
      ST_ADDR: if (cnt_last) begin
        st_d     = ST_CSSU;
        cnt_load = 1'b1;
        cnt_val  = len_q[PH_CSSU];
      end
      ST_CSSU: if (cnt_last) begin
        st_d     = ST_STRB;
        cnt_load = 1'b1;
        cnt_val  = len_q[PH_STRB];
      end
      ST_STRB: if (cnt_last) begin
        st_d     = ST_HOLD;
        cnt_load = 1'b1;
        cnt_val  = len_q[PH_HOLD];
      end
      ST_HOLD: if (cnt_last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  i80w_pin_drv u_pins (
    .clk     (clk),
    .rst     (rst),
    .st_next (rst ? ST_IDLE : st_d),
    .cs_n    (lcd_cs_n),
    .wr_n    (lcd_wr_n),
    .oe      (lcd_data_oe)
  );
endmodule

// File: rtl/i80w_seq_chk.sv
module i80w_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          busy,
  input logic          lcd_rs,
  input logic          lcd_cs_n,
  input logic          lcd_wr_n,
  input logic [DW-1:0] lcd_data,
  input logic          lcd_data_oe,
  input logic          done
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (lcd_cs_n && lcd_wr_n && !lcd_data_oe && !busy));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n |-> !lcd_cs_n);

  p_cs_before_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_wr_n) |-> $past(!lcd_cs_n));

  p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(lcd_cs_n) && !$past(rst)) |-> $past(lcd_wr_n));

  p_oe_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
    lcd_data_oe |-> !lcd_cs_n);

  p_oe_at_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_wr_n) |-> lcd_data_oe);

  p_payload_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

  p_done_at_release_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(lcd_cs_n));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_cs_n) |-> ($past(lcd_cs_n, 1) && $past(lcd_cs_n, 2)));
endmodule

bind i80w_seq i80w_seq_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .busy        (busy),
  .lcd_rs      (lcd_rs),
  .lcd_cs_n    (lcd_cs_n),
  .lcd_wr_n    (lcd_wr_n),
  .lcd_data    (lcd_data),
  .lcd_data_oe (lcd_data_oe),
  .done        (done)
);

// File: tb/tb_i80w_seq.sv
module tb_i80w_seq;
  localparam int DW = 8;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_use = 1'b0;
  logic [TW-1:0] cfg_cs_setup = '0, cfg_wr_setup = '0, cfg_wr_active = '0, cfg_wr_hold = '0;
  logic          req_valid = 1'b0, req_cmd = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, lcd_rs, lcd_cs_n, lcd_wr_n, lcd_data_oe, busy, done;
  logic [DW-1:0] lcd_data;

  always #4 clk = ~clk;   // 125 MHz

  i80w_seq #(.DW(DW), .TW(TW)) dut (
    .clk(clk), .rst(rst), .cfg_use(cfg_use),
    .cfg_cs_setup(cfg_cs_setup), .cfg_wr_setup(cfg_wr_setup),
    .cfg_wr_active(cfg_wr_active), .cfg_wr_hold(cfg_wr_hold),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_data(req_data),
    .lcd_rs(lcd_rs), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data),
    .lcd_data_oe(lcd_data_oe), .busy(busy), .done(done)
  );

  typedef struct {
    string        note;
    logic         cmd;
    logic [DW-1:0] data;
    int           cs, ws, wa, wh;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // driver: push the expected item, offer it, hold until taken
  task automatic send(input string note, input logic cmd, input logic [DW-1:0] d,
                      input logic use_c, input int cs, input int ws, input int wa,
                      input int wh, input bit scramble);
    exp_t e;
    e.note = note; e.cmd = cmd; e.data = d;
    if (use_c) begin e.cs = cs; e.ws = ws; e.wa = wa; e.wh = wh; end
    else       begin e.cs = 0;  e.ws = 0;  e.wa = 1;  e.wh = 0;  end   // R7 defaults
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_data = d; cfg_use = use_c;
    cfg_cs_setup = TW'(cs); cfg_wr_setup = TW'(ws);
    cfg_wr_active = TW'(wa); cfg_wr_hold = TW'(wh);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin   // R8: pins change after acceptance
      req_cmd = ~cmd; req_data = ~d; cfg_use = ~use_c;
      cfg_cs_setup = 4'hF; cfg_wr_setup = 4'hF; cfg_wr_active = 4'hF; cfg_wr_hold = 4'hF;
    end
  endtask

  // monitor: compare pins cycle by cycle against the popped item
  bit   act_on = 0;
  int   idx = 0;
  exp_t cur;
  int   c1, c2, c3, c4;

  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst) begin
        act_on = 0;
      end else begin
        if (act_on) begin
          idx++;
          if (idx <= c4) begin
            chk({cur.note, " R1 ready low while busy"}, req_ready, 0);
            chk({cur.note, " R1 busy high"}, busy, 1);
            chk({cur.note, " R2 rs"}, lcd_rs, !cur.cmd);
            chk({cur.note, " R9 no done mid-transfer"}, done, 0);
            if (idx <= c1) begin
              chk({cur.note, " R2 cs_n high in setup"}, lcd_cs_n, 1);
              chk({cur.note, " R2 wr_n high"}, lcd_wr_n, 1);
              chk({cur.note, " R6 oe low"}, lcd_data_oe, 0);
            end else if (idx <= c2) begin
              chk({cur.note, " R3 cs_n low"}, lcd_cs_n, 0);
              chk({cur.note, " R3 wr_n high"}, lcd_wr_n, 1);
              chk({cur.note, " R6 oe low"}, lcd_data_oe, 0);
            end else if (idx <= c3) begin
              chk({cur.note, " R4 cs_n low"}, lcd_cs_n, 0);
              chk({cur.note, " R4 wr_n low"}, lcd_wr_n, 0);
              chk({cur.note, " R6 oe high"}, lcd_data_oe, 1);
              chk({cur.note, " R6 data"}, lcd_data, cur.data);
            end else begin
              chk({cur.note, " R5 cs_n low in hold"}, lcd_cs_n, 0);
              chk({cur.note, " R5 wr_n high"}, lcd_wr_n, 1);
              chk({cur.note, " R6 oe high"}, lcd_data_oe, 1);
              chk({cur.note, " R6 data"}, lcd_data, cur.data);
            end
          end else begin
            chk({cur.note, " R10 cs_n released"}, lcd_cs_n, 1);
            chk({cur.note, " R6 oe off"}, lcd_data_oe, 0);
            chk({cur.note, " R9 done pulse"}, done, 1);
            chk({cur.note, " R10 ready in done cycle"}, req_ready, 1);
            act_on = 0;
          end
        end else if (idx != -1) begin
          chk("idle R9 done low", done, 0);
          chk("idle R1 ready high", req_ready, 1);
          idx = -1;
        end
        if (!act_on && req_valid && req_ready) begin
          if (q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1: actual unexpected accept expected none");
          end else begin
            cur = q.pop_front();
            c1 = cur.cs + 1; c2 = c1 + cur.ws + 1;
            c3 = c2 + cur.wa + 1; c4 = c3 + cur.wh + 1;
            act_on = 1; idx = 0;
          end
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk("R11 reset cs_n", lcd_cs_n, 1);
    chk("R11 reset wr_n", lcd_wr_n, 1);
    chk("R11 reset oe", lcd_data_oe, 0);
    chk("R11 reset ready", req_ready, 1);
    chk("R11 reset done", done, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    send("R7 defaults", 1'b1, 8'h3C, 1'b0, 9, 9, 9, 9, 0);
    send("prog", 1'b0, 8'h81, 1'b1, 2, 1, 3, 2, 0);
    send("minimum", 1'b1, 8'hFF, 1'b1, 0, 0, 0, 0, 0);
    send("R8 sampled", 1'b0, 8'h5A, 1'b1, 1, 3, 0, 4, 1);
    repeat (30) @(negedge clk);
    send("R10 b2b-a", 1'b0, 8'h11, 1'b1, 0, 1, 0, 0, 0);
    send("R10 b2b-b", 1'b1, 8'h22, 1'b1, 1, 0, 2, 1, 0);
    send("R10 b2b-c", 1'b0, 8'h33, 1'b0, 5, 5, 5, 5, 0);
    send("max", 1'b1, 8'hC3, 1'b1, 15, 15, 15, 15, 0);
    while (q.size() != 0 || act_on) @(negedge clk);
    repeat (3) @(negedge clk);

    // R11: reset lands while the strobe is low
    send("R11 abort", 1'b0, 8'h77, 1'b1, 0, 0, 15, 3, 0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #3;
    chk("R11 mid reset cs_n", lcd_cs_n, 1);
    chk("R11 mid reset wr_n", lcd_wr_n, 1);
    chk("R11 mid reset oe", lcd_data_oe, 0);
    chk("R11 mid reset ready", req_ready, 1);
    chk("R11 mid reset done", done, 0);
    @(negedge clk); rst = 1'b0;
    send("after reset", 1'b1, 8'h9E, 1'b1, 1, 1, 1, 1, 0);
    while (q.size() != 0 || act_on) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule